// File: doc/BRIEF.md
# Single-Channel 8-bit Pulse-Width Modulator

This block drives one output pin with a pulse train. A single 32-bit control word sets it up. The word is written and read over a plain memory-mapped port made of an address, a write strobe, write data and read data. A reload field divides the input clock, so the phase counter takes one step every *reload* clocks. One output period is 256 of those steps. A compare field picks the step at which the output goes from its inactive (low) level to its active (high) level. The compare value therefore encodes the inactive share of the period: a small value gives a wide high pulse and a large value gives a narrow one.

An enable bit starts and stops generation. While the channel is stopped, a separate level bit decides what the pin shows. A new reload or compare value written during generation waits in the control word until the current period ends, so a period is never cut short or stretched by a write. The bus port has no handshake: a write takes effect at the clock edge where the strobe is high, and read data follows the address in the same cycle.

Top module: `pwm8_channel`

## Requirements
- R1: After reset every control bit is 0, a read of offset 0 returns 0x0000_0000, and `pwm_out` is low.
- R2: The control word sits at offset 0. Its fields are: bit 31 enable, bit 30 idle level, bits 15:8 reload, bits 7:0 compare. A read of offset 0 returns these bits as last written, with bits 29:16 as 0. A write to any other offset changes nothing, and a read of any other offset returns 0.
- R3: A reload value r from 1 to 255 makes one phase step last r clocks. A reload of 0 makes one step last 256 clocks. A full period lasts 256 steps.
- R4: While running, `pwm_out` is low in the steps where the phase is below the compare value c, and high from step c to step 255. The output therefore stays high for (256 − c) × divisor clocks per period.
- R5: A reload or compare write made during generation takes effect only at the start of the next period, which is when the phase wraps from 255 to 0.
- R6: Once the enable bit has been cleared, `pwm_out` equals the idle-level bit from the next clock onward, and the prescaler and phase counter are cleared.
- R7: Take the edge that sets the enable bit. At the edge after it, the prescaler and phase counter start from 0 and the control word's reload and compare values are loaded, and `pwm_out` still shows the idle level. From the edge after that, `pwm_out` follows phase 0 of a fresh period.
- R8: The idle-level bit has no effect on `pwm_out` while generation is running.
- R9: While the channel is disabled, writes to reload or compare leave `pwm_out` unchanged at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Register offset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | Registered pulse output |

## Verification
Internal errors show at the ports within a bounded time:
- A prescaler that counts to the wrong limit moves the first low-to-high switch, which shows within c × divisor clocks of the start.
- A phase counter that skips or stalls shifts that same switch or the wrap point, which shows within one period.
- Shadow values reloaded at the wrong moment change the pulse width in the very period where the write lands, not the following one.
- Idle handling that is wrong shows one clock after enable changes.

The bench compares every output cycle of whole periods against an arithmetic model. The sweep covers several divisors, including the 256 case, and compare values at both ends of their range.

// File: rtl/pwm8_pkg.sv
`timescale 1ns/1ps
package pwm8_pkg;
  localparam int REG_W   = 32;
  localparam int CNT_W   = 8;
  localparam int EN_BIT  = 31;
  localparam int LVL_BIT = 30;
  localparam int RLD_LSB = 8;
  localparam int CMP_LSB = 0;

  typedef struct packed {
    logic             en;
    logic             lvl;
    logic [CNT_W-1:0] rld;
    logic [CNT_W-1:0] cmp;
  } ctrl_t;
endpackage

// File: rtl/pwm8_ctrl_reg.sv
`timescale 1ns/1ps
module pwm8_ctrl_reg
  import pwm8_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output ctrl_t             ctrl
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = REG_ADDR[ADDR_W-1:0];

  logic hit;
  assign hit = (addr == HIT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (we && hit) begin
      ctrl.en  <= wdata[EN_BIT];
      ctrl.lvl <= wdata[LVL_BIT];
      ctrl.rld <= wdata[RLD_LSB +: CNT_W];
      ctrl.cmp <= wdata[CMP_LSB +: CNT_W];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[EN_BIT]             = ctrl.en;
      rdata[LVL_BIT]            = ctrl.lvl;
      rdata[RLD_LSB +: CNT_W]   = ctrl.rld;
      rdata[CMP_LSB +: CNT_W]   = ctrl.cmp;
    end
  end

  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hit) |=> $stable(ctrl)); // R2
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ctrl)); // R2
endmodule

// File: rtl/pwm8_prescale.sv
`timescale 1ns/1ps
module pwm8_prescale #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] reload,
  output logic         tick
);
  localparam logic [W:0] FULL_DIV = {1'b1, {W{1'b0}}};

  logic [W-1:0] cnt_q;
  logic [W:0]   div;

  assign div  = (reload == '0) ? FULL_DIV : {1'b0, reload};
  assign tick = !clr && ({1'b0, cnt_q} == (div - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> ({1'b0, cnt_q} < div)); // R3
  AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/pwm8_core.sv
`timescale 1ns/1ps
module pwm8_core
  import pwm8_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         lvl,
  input  logic [W-1:0] rld_reg,
  input  logic [W-1:0] cmp_reg,
  output logic         pwm_out
);
  localparam logic [W-1:0] PH_MAX = '1;

  logic         run_q;
  logic         idle;
  logic         tick;
  logic         wrap;
  logic [W-1:0] phase_q;
  logic [W-1:0] rld_a;
  logic [W-1:0] cmp_a;

  assign idle = !(en && run_q);
  assign wrap = tick && (phase_q == PH_MAX);

  pwm8_prescale #(.W(W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (idle),
    .reload (rld_a),
    .tick   (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= '0;
      rld_a   <= '0;
      cmp_a   <= '0;
      pwm_out <= 1'b0;
    end else begin
      run_q <= en;
      if (idle || wrap) begin
        rld_a <= rld_reg;
        cmp_a <= cmp_reg;
      end
      if (idle)      phase_q <= '0;
      else if (tick) phase_q <= phase_q + 1'b1;
      pwm_out <= idle ? lvl : (phase_q >= cmp_a);
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !wrap) |=> ($stable(rld_a) && $stable(cmp_a))); // R5
  AST_PHASE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !tick) |=> $stable(phase_q)); // R3
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && tick) |=> (phase_q == $past(phase_q) + 1'b1)); // R4
  AST_START_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !run_q) |=> (phase_q == '0 && rld_a == $past(rld_reg) && cmp_a == $past(cmp_reg))); // R7
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pwm_out == $past(lvl))); // R6
endmodule

// File: rtl/pwm8_channel.sv
`timescale 1ns/1ps
module pwm8_channel
  import pwm8_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              pwm_out
);
  ctrl_t ctrl;

  pwm8_ctrl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(0)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .we    (bus_we),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .ctrl  (ctrl)
  );

  pwm8_core #(.W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl.en),
    .lvl     (ctrl.lvl),
    .rld_reg (ctrl.rld),
    .cmp_reg (ctrl.cmp),
    .pwm_out (pwm_out)
  );
endmodule

// File: tb/pwm8_channel_tb.sv
`timescale 1ns/1ps
module pwm8_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm_out;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pwm8_channel #(.ADDR_W(4)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (addr),
    .bus_we    (we),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .pwm_out   (pwm_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
    addr = '0;
  endtask

  function automatic int dv(input logic [7:0] r);
    return (r == 8'd0) ? 256 : int'(r);
  endfunction

  function automatic logic model(input int n, input int d0, input int c0,
                                 input int d1, input int c1, input logic lv);
    int m, ph, c;
    if (n == 0) return lv;
    m = n - 1;
    if (m < 256 * d0) begin
      ph = m / d0; c = c0;
    end else begin
      m = m - 256 * d0;
      ph = (m / d1) % 256; c = c1;
    end
    return (ph >= c);
  endfunction

  task automatic run_seq(input string req, input logic [7:0] r0, input logic [7:0] c0,
                         input logic [7:0] r1, input logic [7:0] c1, input logic lv,
                         input int chg_at, input int ncyc);
    int   mism = 0;
    int   fn = -1;
    logic fa = 1'b0;
    logic fe = 1'b0;
    logic e;
    wr(4'd0, {1'b1, lv, 14'b0, r0, c0});
    for (int n = 0; n < ncyc; n++) begin
      @(posedge clk);
      @(negedge clk);
      e = model(n, dv(r0), int'(c0), dv(r1), int'(c1), lv);
      if (pwm_out !== e) begin
        if (mism == 0) begin fn = n; fa = pwm_out; fe = e; end
        mism++;
      end
      if (n == chg_at) begin
        addr = '0; wdata = {1'b1, lv, 14'b0, r1, c1}; we = 1'b1;
      end else begin
        we = 1'b0;
      end
    end
    we = 1'b0;
    total++;
    if (mism != 0) begin
      bad++;
      $display("FAIL %s rld=%0d cmp=%0d cycle=%0d act=%0b exp=%0b (mismatches %0d)",
               req, r0, c0, fn, fa, fe, mism);
    end
    // R6: clearing enable shows the idle level one clock later
    wr(4'd0, {1'b0, ~lv, 14'b0, r0, c0});
    @(posedge clk);
    @(negedge clk);
    chk("R6 idle level after disable", {31'b0, pwm_out}, {31'b0, ~lv});
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    int          hold_bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out after reset", {31'b0, pwm_out}, 32'd0);
    rd(4'd0, v);
    chk("R1 reg after reset", v, 32'd0);

    // R2: readback and address decode
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, v);
    chk("R2 readback all ones", v, 32'hC000_FFFF);
    wr(4'd1, 32'h0000_0000);
    rd(4'd0, v);
    chk("R2 other offset write ignored", v, 32'hC000_FFFF);
    rd(4'd1, v);
    chk("R2 other offset reads zero", v, 32'd0);
    wr(4'd0, 32'h4012_A53C);
    rd(4'd0, v);
    chk("R2 readback pattern", v, 32'h4000_A53C);
    wr(4'd0, 32'h0000_0000);

    // R9: disabled output ignores reload/compare
    wr(4'd0, {1'b0, 1'b1, 14'b0, 8'd1, 8'd1});
    hold_bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pwm_out !== 1'b1) hold_bad++;
      if (i == 10) begin addr = '0; wdata = {1'b0, 1'b1, 14'b0, 8'd3, 8'd200}; we = 1'b1; end
      else we = 1'b0;
    end
    chk("R9 disabled holds level high", hold_bad, 0);
    wr(4'd0, {1'b0, 1'b0, 14'b0, 8'd2, 8'd9});
    hold_bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i > 0 && pwm_out !== 1'b0) hold_bad++;
    end
    chk("R9 disabled holds level low", hold_bad, 0);

    // R3 R4 R7: sweep of divisors and compare values, two periods each
    for (int r = 1; r <= 4; r++) begin
      for (int k = 0; k < 6; k++) begin
        logic [7:0] cv;
        case (k)
          0: cv = 8'd1;   1: cv = 8'd2;   2: cv = 8'd127;
          3: cv = 8'd128; 4: cv = 8'd254; default: cv = 8'd255;
        endcase
        run_seq("R3/R4/R7 sweep", 8'(r), cv, 8'(r), cv, k[0], -1, 512 * r + 3);
      end
    end

    // R3: reload 0 means divide by 256
    run_seq("R3 reload zero", 8'd0, 8'd200, 8'd0, 8'd200, 1'b0, -1, 65536 + 300);

    // R5: mid-period changes wait for the wrap
    run_seq("R5 change at wrap", 8'd1, 8'd64, 8'd2, 8'd192, 1'b0, 100, 256 + 1024 + 3);
    run_seq("R5 change at wrap", 8'd3, 8'd250, 8'd1, 8'd5, 1'b1, 40, 768 + 512 + 3);

    // R8: idle level set while running has no effect
    run_seq("R8 level ignored while running", 8'd2, 8'd100, 8'd2, 8'd100, 1'b1, 7, 1024 + 3);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule